// File: doc/BRIEF.md
# Serial Command Receiver with Error Lockout

This block is the front end of a serial memory's command port. While chip select is high it takes in asynchronous characters from the host, one bit per strobe. A separate oversampling stage, which is not part of this block, supplies that strobe. Each character is a start bit of 0, eight data bits sent least significant first, an optional even parity bit, and a stop bit of 1. The block decodes the first character as an opcode and collects any argument characters that follow. It then either issues a one-cycle command pulse to the memory core or updates its own mode state.

A bad character locks the whole port. A bad character is one with a parity mismatch, a stop bit sampled as 0, or an opcode outside the known set. While locked, the port ignores every input and keeps its serial output disabled. Driving chip select low unlocks the port. The error flags survive that reset, so a status read issued afterwards can report them. The status byte always starts with the bits 1,0,1. A host can therefore tell a healthy device from a floating line, which reads all ones or all zeros.

Top module: `cmdrx_top`

## Requirements
- R1: A character is recognised only while `cs_i` is high. It is a 0 start bit, then eight data bits least significant first, then an optional parity bit, then a stop bit, each sampled on a cycle where `bit_stb_i` is high.
- R2: With `par_en_i` high, a parity bit is expected after the data, and the data plus parity must hold an even number of ones. With `par_en_i` low, no parity bit is expected, and the bit after the eighth data bit is taken as the stop bit.
- R3: A parity mismatch, or a stop bit sampled as 0, sets the parity-error flag and raises `locked_o`.
- R4: Any first character other than these opcodes sets the instruction-error flag and raises `locked_o`: write-enable 8'h1E, write-disable 8'h1C, status read 8'h2D, sequential read 8'h3B, erase-all 8'h4E, write-all 8'h4F.
- R5: While `locked_o` is high, `sdo_oe_o` stays low, no command is issued, and received characters change no state.
- R6: With `cs_i` low, the lock clears and any partly received character or command is dropped. The write-enable flag `wr_en_o` keeps its value.
- R7: The status-read opcode shifts `sts_o` out on `sdo_o`, most significant bit first, one bit per strobe, with `sdo_oe_o` high. `sts_o` holds, from bit 7 down to bit 0: 1, 0, 1, the parity-error flag, the instruction-error flag, the busy flag, 0, 0.
- R8: The busy bit follows `core_busy_i` when the read starts. A read during a program/erase cycle gives 8'hA4, and a read with no cycle running gives 8'hA0.
- R9: The error flags stay set through chip-select resets. They clear only after a status read has shifted all eight bits out.
- R10: Sequential read takes two address characters, high byte first. It then pulses `cmd_vld_o` for one cycle with `cmd_op_o`=8'h3B and the assembled address on `cmd_addr_o`.
- R11: Write-enable sets `wr_en_o` and write-disable clears it. Erase-all, and write-all with its single data character on `cmd_data_o`, are issued with `cmd_addr_o`=0, covering the whole array, and only while `wr_en_o` is high. Otherwise they are dropped without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, high to enable |
| par_en_i | input | 1 | Parity expected when high |
| bit_stb_i | input | 1 | Bit sampling strobe |
| rx_i | input | 1 | Serial data in |
| core_busy_i | input | 1 | Memory core program/erase in progress |
| cmd_vld_o | output | 1 | One-cycle command pulse |
| cmd_op_o | output | 8 | Command opcode |
| cmd_addr_o | output | ADDR_W | Command address |
| cmd_data_o | output | 8 | Write-all data byte |
| wr_en_o | output | 1 | Write-enable mode flag |
| locked_o | output | 1 | Port is locked by an error |
| sts_o | output | 8 | Current status byte |
| sdo_o | output | 1 | Serial status data out |
| sdo_oe_o | output | 1 | Output enable for `sdo_o` |

## Verification
The bench builds the block with `ADDR_W` = 16. This makes sequential read need exactly two address characters, so the high-byte-first assembly shows in the captured address. A vector table runs known and unknown opcodes under both parity settings. Each vector is followed by a chip-select reset and a status read, which shows that the flags persist and then clear. Directed cases cover parity and stop-bit faults, inputs sent while locked, an aborted character, the write-enable gate, and both busy values.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;

    localparam int unsigned CHAR_W = 8;

    localparam logic [7:0] OPC_WREN  = 8'h1E;
    localparam logic [7:0] OPC_WRDIS = 8'h1C;
    localparam logic [7:0] OPC_RDSTS = 8'h2D;
    localparam logic [7:0] OPC_RDSEQ = 8'h3B;
    localparam logic [7:0] OPC_ERALL = 8'h4E;
    localparam logic [7:0] OPC_WRALL = 8'h4F;

    localparam logic [2:0] STS_PREFIX = 3'b101;

    typedef enum logic [1:0] {FR_IDLE, FR_DATA, FR_PAR, FR_STOP} fr_state_e;
    typedef enum logic {DC_OPC, DC_ARG} dc_state_e;

    function automatic logic opc_known(input logic [7:0] op);
        return (op == OPC_WREN)  || (op == OPC_WRDIS) || (op == OPC_RDSTS) ||
               (op == OPC_RDSEQ) || (op == OPC_ERALL) || (op == OPC_WRALL);
    endfunction

    function automatic logic [3:0] opc_args(input logic [7:0] op, input logic [3:0] addr_bytes);
        if (op == OPC_RDSEQ) return addr_bytes;
        if (op == OPC_WRALL) return 4'd1;
        return 4'd0;
    endfunction

endpackage

// File: rtl/cmdrx_frame.sv
module cmdrx_frame
    import cmdrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              stb_i,
    input  logic              rx_i,
    input  logic              par_en_i,
    output logic              vld_o,
    output logic [CHAR_W-1:0] octet_o,
    output logic              bad_o
);
    localparam int unsigned CNT_W = $clog2(CHAR_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAR_W - 1);

    typedef struct packed {
        fr_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [CHAR_W-1:0] sh;
        logic              par;
        logic              vld;
        logic              bad;
        logic [CHAR_W-1:0] octet;
    } fr_t;

    fr_t d, q;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        d.bad = 1'b0;
        if (clr_i) begin
            d.st = FR_IDLE;
        end else if (stb_i) begin
            case (q.st)
                FR_IDLE: begin
                    if (!rx_i) begin
                        d.st  = FR_DATA;
                        d.cnt = '0;
                        d.par = 1'b0;
                    end
                end
                FR_DATA: begin
                    d.sh  = {rx_i, q.sh[CHAR_W-1:1]};
                    d.par = q.par ^ rx_i;
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == LAST) d.st = par_en_i ? FR_PAR : FR_STOP;
                end
                FR_PAR: begin
                    d.par = q.par ^ rx_i;
                    d.st  = FR_STOP;
                end
                default: begin
                    d.vld   = 1'b1;
                    d.octet = q.sh;
                    d.bad   = !rx_i || (par_en_i && q.par);
                    d.st    = FR_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: FR_IDLE, cnt: '0, sh: '0, par: 1'b0, vld: 1'b0, bad: 1'b0, octet: '0};
        end else begin
            q <= d;
        end
    end

    assign vld_o   = q.vld;
    assign octet_o = q.octet;
    assign bad_o   = q.bad;

    AST_FR_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |=> !vld_o); // R1
    AST_FR_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !vld_o); // R6

endmodule

// File: rtl/cmdrx_decode.sv
module cmdrx_decode
    import cmdrx_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              vld_i,
    input  logic [CHAR_W-1:0] octet_i,
    input  logic              bad_i,
    output logic              cmd_vld_o,
    output logic [7:0]        cmd_op_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic [7:0]        cmd_data_o,
    output logic              wen_o,
    output logic              perr_o,
    output logic              ierr_o,
    output logic              rd_go_o
);
    localparam int unsigned ADDR_BYTES = ADDR_W / CHAR_W;
    localparam logic [3:0]  NAB = 4'(ADDR_BYTES);

    typedef struct packed {
        dc_state_e         st;
        logic [3:0]        argc;
        logic [7:0]        opc;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic              cmd_vld;
        logic [7:0]        cmd_op;
        logic [ADDR_W-1:0] cmd_addr;
        logic [7:0]        cmd_data;
        logic              wen;
        logic              perr;
        logic              ierr;
        logic              rd_go;
    } dc_t;

    dc_t d, q;
    logic              fire;
    logic [7:0]        fop;
    logic [ADDR_W-1:0] naddr;

    always_comb begin
        d         = q;
        d.cmd_vld = 1'b0;
        d.perr    = 1'b0;
        d.ierr    = 1'b0;
        d.rd_go   = 1'b0;
        fire      = 1'b0;
        fop       = q.opc;
        naddr     = (q.addr << CHAR_W) | ADDR_W'(octet_i);
        if (clr_i) begin
            d.st   = DC_OPC;
            d.argc = '0;
        end else if (vld_i) begin
            if (bad_i) begin
                d.perr = 1'b1;
                d.st   = DC_OPC;
            end else if (q.st == DC_OPC) begin
                if (opc_known(octet_i)) begin
                    d.opc = octet_i;
                    fop   = octet_i;
                    if (opc_args(octet_i, NAB) == 4'd0) begin
                        fire = 1'b1;
                    end else begin
                        d.st   = DC_ARG;
                        d.argc = opc_args(octet_i, NAB);
                    end
                end else begin
                    d.ierr = 1'b1;
                end
            end else begin
                if (q.opc == OPC_RDSEQ) d.addr = naddr;
                else                    d.data = octet_i;
                d.argc = q.argc - 4'd1;
                if (q.argc == 4'd1) begin
                    fire = 1'b1;
                    d.st = DC_OPC;
                end
            end
        end
        if (fire) begin
            case (fop)
                OPC_WREN:  d.wen   = 1'b1;
                OPC_WRDIS: d.wen   = 1'b0;
                OPC_RDSTS: d.rd_go = 1'b1;
                OPC_RDSEQ: begin
                    d.cmd_vld  = 1'b1;
                    d.cmd_op   = fop;
                    d.cmd_addr = d.addr;
                end
                default: begin
                    if (q.wen) begin
                        d.cmd_vld  = 1'b1;
                        d.cmd_op   = fop;
                        d.cmd_addr = '0;
                        d.cmd_data = d.data;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: DC_OPC, argc: '0, opc: '0, addr: '0, data: '0, cmd_vld: 1'b0,
                   cmd_op: '0, cmd_addr: '0, cmd_data: '0, wen: 1'b0, perr: 1'b0,
                   ierr: 1'b0, rd_go: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign cmd_vld_o  = q.cmd_vld;
    assign cmd_op_o   = q.cmd_op;
    assign cmd_addr_o = q.cmd_addr;
    assign cmd_data_o = q.cmd_data;
    assign wen_o      = q.wen;
    assign perr_o     = q.perr;
    assign ierr_o     = q.ierr;
    assign rd_go_o    = q.rd_go;

    AST_DC_CLR_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !cmd_vld_o && !rd_go_o); // R5
    AST_DC_ALL_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld_o && (cmd_op_o == OPC_ERALL || cmd_op_o == OPC_WRALL) |-> wen_o); // R11
    AST_DC_WEN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> $stable(wen_o)); // R6

endmodule

// File: rtl/cmdrx_status.sv
module cmdrx_status
    import cmdrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_i,
    input  logic       stb_i,
    input  logic       busy_i,
    input  logic       perr_i,
    input  logic       ierr_i,
    input  logic       rd_go_i,
    output logic       lock_o,
    output logic [7:0] sts_o,
    output logic       sdo_o,
    output logic       sdo_oe_o
);
    localparam int unsigned STS_W = 8;
    localparam int unsigned CNT_W = $clog2(STS_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STS_W - 1);

    typedef struct packed {
        logic             perr;
        logic             ierr;
        logic             lock;
        logic             act;
        logic [CNT_W-1:0] cnt;
        logic [STS_W-1:0] sh;
    } st_t;

    st_t d, q;
    logic [STS_W-1:0] sts;

    always_comb begin
        sts = {STS_PREFIX, q.perr, q.ierr, busy_i, 2'b00};
        d   = q;
        if (!cs_i) begin
            d.lock = 1'b0;
            d.act  = 1'b0;
        end else if (q.act && stb_i) begin
            d.sh  = {q.sh[STS_W-2:0], 1'b0};
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == LAST) begin
                d.act  = 1'b0;
                d.perr = 1'b0;
                d.ierr = 1'b0;
            end
        end else if (rd_go_i) begin
            d.sh  = sts;
            d.act = 1'b1;
            d.cnt = '0;
        end
        if (cs_i && perr_i) begin
            d.perr = 1'b1;
            d.lock = 1'b1;
        end
        if (cs_i && ierr_i) begin
            d.ierr = 1'b1;
            d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{perr: 1'b0, ierr: 1'b0, lock: 1'b0, act: 1'b0, cnt: '0, sh: '0};
        end else begin
            q <= d;
        end
    end

    assign lock_o   = q.lock;
    assign sts_o    = sts;
    assign sdo_o    = q.sh[STS_W-1];
    assign sdo_oe_o = q.act && !q.lock;

    AST_ST_ERR_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_i && (perr_i || ierr_i) |=> lock_o); // R3
    AST_ST_LOCK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |-> !sdo_oe_o); // R5
    AST_ST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o && cs_i |=> lock_o); // R5
    AST_ST_CS_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_i |=> !lock_o); // R6
    AST_ST_PERR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        q.perr && !(q.act && stb_i && cs_i && q.cnt == LAST) |=> q.perr); // R9

endmodule

// File: rtl/cmdrx_top.sv
module cmdrx_top
    import cmdrx_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              par_en_i,
    input  logic              bit_stb_i,
    input  logic              rx_i,
    input  logic              core_busy_i,
    output logic              cmd_vld_o,
    output logic [7:0]        cmd_op_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic [7:0]        cmd_data_o,
    output logic              wr_en_o,
    output logic              locked_o,
    output logic [7:0]        sts_o,
    output logic              sdo_o,
    output logic              sdo_oe_o
);
    logic              clr;
    logic              fr_vld;
    logic [CHAR_W-1:0] fr_octet;
    logic              fr_bad;
    logic              dc_perr;
    logic              dc_ierr;
    logic              dc_rd_go;

    assign clr = !cs_i || locked_o;

    cmdrx_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr),
        .stb_i    (bit_stb_i),
        .rx_i     (rx_i),
        .par_en_i (par_en_i),
        .vld_o    (fr_vld),
        .octet_o  (fr_octet),
        .bad_o    (fr_bad)
    );

    cmdrx_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr),
        .vld_i      (fr_vld),
        .octet_i    (fr_octet),
        .bad_i      (fr_bad),
        .cmd_vld_o  (cmd_vld_o),
        .cmd_op_o   (cmd_op_o),
        .cmd_addr_o (cmd_addr_o),
        .cmd_data_o (cmd_data_o),
        .wen_o      (wr_en_o),
        .perr_o     (dc_perr),
        .ierr_o     (dc_ierr),
        .rd_go_o    (dc_rd_go)
    );

    cmdrx_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_i     (cs_i),
        .stb_i    (bit_stb_i),
        .busy_i   (core_busy_i),
        .perr_i   (dc_perr),
        .ierr_i   (dc_ierr),
        .rd_go_i  (dc_rd_go),
        .lock_o   (locked_o),
        .sts_o    (sts_o),
        .sdo_o    (sdo_o),
        .sdo_oe_o (sdo_oe_o)
    );

    AST_TOP_LOCK_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> !cmd_vld_o); // R5

endmodule

// File: tb/cmdrx_top_tb_top.sv
`timescale 1ns/1ps
module cmdrx_top_tb_top;
    localparam int ADDR_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, pe = 1'b1, stb = 1'b0, rx = 1'b1, busy = 1'b0;
    logic              cmd_vld, wr_en, locked, sdo, sdo_oe;
    logic [7:0]        cmd_op, cmd_data, sts;
    logic [ADDR_W-1:0] cmd_addr;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int cap_n  = 0;
    logic [7:0]        cap_op   = '0;
    logic [7:0]        cap_data = '0;
    logic [ADDR_W-1:0] cap_addr = '0;

    always #2.5 clk = ~clk;

    cmdrx_top #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .par_en_i(pe), .bit_stb_i(stb),
        .rx_i(rx), .core_busy_i(busy), .cmd_vld_o(cmd_vld), .cmd_op_o(cmd_op),
        .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data), .wr_en_o(wr_en),
        .locked_o(locked), .sts_o(sts), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (cmd_vld) begin
            cap_n    = cap_n + 1;
            cap_op   = cmd_op;
            cap_addr = cmd_addr;
            cap_data = cmd_data;
        end
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic put_bit(input logic v);
        @(negedge clk);
        rx  = v;
        stb = 1'b1;
        @(negedge clk);
        stb = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input logic flip_par, input logic bad_stop);
        put_bit(1'b0);
        for (int i = 0; i < 8; i++) put_bit(b[i]);
        if (pe) put_bit((^b) ^ flip_par);
        put_bit(!bad_stop);
        rx = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_pulse();
        @(negedge clk);
        cs = 1'b0;
        repeat (3) @(negedge clk);
        cs = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic read_sts(output logic [7:0] v, output logic oe_all, output logic oe_any);
        oe_all = 1'b1;
        oe_any = 1'b0;
        v      = '0;
        for (int i = 7; i >= 0; i--) begin
            v[i]   = sdo;
            oe_all = oe_all & sdo_oe;
            oe_any = oe_any | sdo_oe;
            stb    = 1'b1;
            @(negedge clk);
            stb    = 1'b0;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    // {parity enable, opcode, instruction error expected}
    localparam logic [9:0] VEC [6] = '{
        {1'b1, 8'h1E, 1'b0},
        {1'b0, 8'h1C, 1'b0},
        {1'b1, 8'h00, 1'b1},
        {1'b0, 8'hFF, 1'b1},
        {1'b1, 8'h55, 1'b1},
        {1'b0, 8'h3C, 1'b1}
    };

    initial begin
        logic [7:0] v;
        logic oe_all, oe_any;
        int n0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!locked && !sdo_oe && !cmd_vld && !wr_en, "R5 reset idle", {locked, sdo_oe, cmd_vld, wr_en}, 0);
        chk(sts == 8'hA0, "R7 reset status", sts, 8'hA0);
        cs = 1'b1;
        repeat (2) @(negedge clk);

        for (int k = 0; k < 6; k++) begin
            cs_pulse();
            pe = VEC[k][9];
            send(VEC[k][8:1], 1'b0, 1'b0);
            chk(locked == VEC[k][0], "R4 opcode lock", locked, VEC[k][0]);
            cs_pulse();
            chk(!locked, "R6 unlock", locked, 0);
            send(8'h2D, 1'b0, 1'b0);
            read_sts(v, oe_all, oe_any);
            chk(oe_all && v == {3'b101, 1'b0, VEC[k][0], 1'b0, 2'b00}, "R9 R7 status after reset",
                v, {3'b101, 1'b0, VEC[k][0], 1'b0, 2'b00});
        end

        // R10 sequential read, parity on and off
        pe = 1'b1;
        n0 = cap_n;
        send(8'h3B, 1'b0, 1'b0); send(8'h12, 1'b0, 1'b0); send(8'h34, 1'b0, 1'b0);
        chk(cap_n == n0 + 1 && cap_op == 8'h3B && cap_addr == 16'h1234, "R10 seq read pe1", cap_addr, 16'h1234);
        pe = 1'b0;
        send(8'h3B, 1'b0, 1'b0); send(8'hAB, 1'b0, 1'b0); send(8'hCD, 1'b0, 1'b0);
        chk(cap_n == n0 + 2 && cap_addr == 16'hABCD && !locked, "R2 R1 seq read pe0", cap_addr, 16'hABCD);

        // R8 busy bit
        busy = 1'b1;
        send(8'h2D, 1'b0, 1'b0);
        read_sts(v, oe_all, oe_any);
        chk(oe_all && v == 8'hA4, "R8 busy status", v, 8'hA4);
        busy = 1'b0;
        send(8'h2D, 1'b0, 1'b0);
        read_sts(v, oe_all, oe_any);
        chk(v == 8'hA0, "R8 idle status", v, 8'hA0);

        // R3 parity mismatch, then R5 ignored input while locked
        pe = 1'b1;
        send(8'h1E, 1'b1, 1'b0);
        chk(locked, "R3 parity error locks", locked, 1);
        send(8'h1E, 1'b0, 1'b0);
        send(8'h2D, 1'b0, 1'b0);
        read_sts(v, oe_all, oe_any);
        chk(!oe_any, "R5 no output while locked", oe_any, 0);
        cs_pulse();
        chk(!wr_en, "R5 write-enable ignored while locked", wr_en, 0);
        send(8'h2D, 1'b0, 1'b0);
        read_sts(v, oe_all, oe_any);
        chk(v == 8'hB0, "R9 parity flag reported", v, 8'hB0);
        send(8'h2D, 1'b0, 1'b0);
        read_sts(v, oe_all, oe_any);
        chk(v == 8'hA0, "R9 flags cleared after read", v, 8'hA0);

        // R3 framing error with parity off
        pe = 1'b0;
        send(8'h1E, 1'b0, 1'b1);
        chk(locked, "R3 stop error locks", locked, 1);
        cs_pulse();
        send(8'h2D, 1'b0, 1'b0);
        read_sts(v, oe_all, oe_any);
        chk(v == 8'hB0, "R3 stop error flag", v, 8'hB0);

        // R6 aborted character
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        cs_pulse();
        n0 = cap_n;
        send(8'h3B, 1'b0, 1'b0); send(8'h00, 1'b0, 1'b0); send(8'h7F, 1'b0, 1'b0);
        chk(cap_n == n0 + 1 && cap_addr == 16'h007F && !locked, "R6 abort then clean command", cap_addr, 16'h007F);

        // R11 write-enable gate
        n0 = cap_n;
        send(8'h4E, 1'b0, 1'b0);
        chk(cap_n == n0 && !locked, "R11 erase-all dropped", cap_n, n0);
        send(8'h1E, 1'b0, 1'b0);
        send(8'h4E, 1'b0, 1'b0);
        chk(cap_n == n0 + 1 && cap_op == 8'h4E && cap_addr == 0, "R11 erase-all issued", cap_op, 8'h4E);
        cs_pulse();
        chk(wr_en, "R6 write-enable kept over reset", wr_en, 1);
        send(8'h4F, 1'b0, 1'b0); send(8'h5A, 1'b0, 1'b0);
        chk(cap_n == n0 + 2 && cap_op == 8'h4F && cap_data == 8'h5A, "R11 write-all data", cap_data, 8'h5A);
        send(8'h1C, 1'b0, 1'b0);
        chk(!wr_en, "R11 write-disable", wr_en, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule